// File: doc/BRIEF.md
# MDIO Station Manager

This block is a management-interface master. It turns one command word into a single Clause 22 or Clause 45 management frame on MDC/MDIO. Software or a sequencer hands the command over with a valid/ready handshake. Read data comes back in the upper half of the same command word, which can be read at any time. The unit does not interpret PHY registers or link state.

Each completed frame sets one of three sticky completion flags: address, write or read. A flag stays set until it is cleared by writing ones. A Clause 45 access takes two commands: an address frame whose data field carries the register address, then a read or write frame. A separate configuration word sets the MDC divider and the output hold time. A divider of zero stops MDC.

Back-pressure rule: `cmd_ready` is low for as long as `busy` is high. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_valid` held high while `cmd_ready` is low has no effect.

Top module: `mdio_station_mgr`

## Requirements
- R1: A command transfers only when `cmd_valid && cmd_ready`, and `cmd_ready` equals `!busy`. A transferred word is stored and read back whole on `cmd_rdata`. `cmd_valid` while busy changes neither `cmd_rdata` nor the frame.
- R2: A frame starts only if bit 0 (enable) of the transferred word is 1. A word with bit 0 = 0 is stored, but MDC stays low, `busy` stays low and no flag is set.
- R3: The word layout is: bit 2 = Clause 45 select (0 = Clause 22), bits 7:3 = PHY address, bits 12:8 = device or register address, bits 14:13 = opcode, bits 31:16 = data. The frame on `mdio_o` is sent MSB first and consists of: 32 ones; start code 00 (Clause 45) or 01 (Clause 22); the opcode; the PHY address; the device/register address; turnaround 10; the 16 data bits.
- R4: A frame is a read when opcode bit 1 is set (Clause 45 read = 11, Clause 22 read = 10). For reads, `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 bits sampled on the MDC rising edges of the data phase, MSB first, replace `cmd_rdata[31:16]` when the frame ends. Bits 15:0 keep their value.
- R5: When a frame ends, exactly one flag is set: bit 2 for a Clause 45 opcode 00 (address), bit 0 for a read, and bit 1 for every other frame (write). Clause 45 write = 01 and Clause 22 write = 01. Flags are sticky.
- R6: A pulse on `irq_clr_we` clears each flag whose bit in `irq_clr_data[2:0]` is 1. Bit 3 = 1 clears all three, so 0xF clears all. A flag being set on the same edge stays set.
- R7: The configuration word reads back on `cfg_rdata`. Bits 22:16 hold the divider N, and MDC is high for N clocks and low for N clocks during a frame.
- R8: While the divider is 0, MDC does not toggle and a pending frame holds `busy` high. The frame resumes once a non-zero divider is written.
- R9: The hold value H is in bits 26:24. `mdio_o` changes H+1 clocks after an MDC falling edge. H is clamped to N-2 when H > N-2 (N >= 2).
- R10: `busy` rises on the edge that transfers an enabled command and falls one clock after the final MDC high phase ends. While `busy` is low, `mdc` and `mdio_oe` are low.
- R11: After reset, `cmd_rdata`, `cfg_rdata` and `irq_flags` are 0, `busy`, `mdc` and `mdio_oe` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word can be taken (not busy) |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Stored command word with read data in bits 31:16 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (divider 22:16, hold 26:24) |
| cfg_rdata | output | 32 | Configuration readback |
| irq_clr_we | input | 1 | Flag clear strobe |
| irq_clr_data | input | 4 | Clear mask, bit 3 clears all |
| irq_flags | output | 3 | Sticky flags: 2 address, 1 write, 0 read |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the line |
| mdio_o | output | 1 | Management data to the line |
| mdio_oe | output | 1 | Output enable for mdio_o |

## Verification
The hardest states to reach from the ports are the divider-zero stall in the middle of a pending frame and the clamped hold timing. Both depend on how the configuration interacts with a live frame, not on the command alone. The bench reaches them by writing a zero divider before issuing a command, watching that no MDC edge appears, and then restoring a divider. It also programs a hold larger than the divider allows. A line model follows MDC edges: it captures every driven bit and answers read frames on falling edges. This lets the returned data and the released turnaround be checked against values built from the command fields.

// File: rtl/mdio_sm_pkg.sv
package mdio_sm_pkg;
  // command word field positions (decoded by software and by this block)
  localparam int CMD_EN_BIT   = 0;
  localparam int CMD_C45_BIT  = 2;
  localparam int CMD_PHY_LSB  = 3;
  localparam int CMD_REG_LSB  = 8;
  localparam int CMD_OP_LSB   = 13;
  localparam int CMD_DATA_LSB = 16;
  // configuration word field positions
  localparam int CFG_DIV_LSB  = 16;
  localparam int CFG_HOLD_LSB = 24;
  // completion flag positions
  localparam int FLAG_READ    = 0;
  localparam int FLAG_WRITE   = 1;
  localparam int FLAG_ADDR    = 2;
  localparam int NUM_FLAGS    = 3;

  typedef enum logic [1:0] {
    KIND_ADDR  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_READ  = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W  = 7,
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic [HOLD_W-1:0] hold,
  output logic              mdc,
  output logic              drive_stb,
  output logic              rise_stb,
  output logic              fall_stb
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] hold_eff;
  logic             mdc_q;
  logic             active;
  logic             at_end;

  always_comb begin
    active = run && (div != '0);
    at_end = cnt_q >= (div - 1'b1);
    if (int'(hold) + 2 <= int'(div)) begin
      hold_eff = DIV_W'(hold);
    end else if (div >= DIV_W'(2)) begin
      hold_eff = div - DIV_W'(2);
    end else begin
      hold_eff = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (div != '0) begin
      if (at_end) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mdc       = mdc_q;
  assign rise_stb  = active && !mdc_q && at_end;
  assign fall_stb  = active &&  mdc_q && at_end;
  assign drive_stb = active && !mdc_q && (cnt_q == hold_eff);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_sm_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              c45,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_stb,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              run,
  output logic              done,
  output frame_kind_e       kind,
  output logic [DATA_W-1:0] rx_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int FRAME_LEN = DATA_POS + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] frame_q;
  logic [CNT_W-1:0]     bcnt_q;
  logic                 run_q, tail_q, done_q, rd_q, o_q, oe_q;
  frame_kind_e          kind_q;
  logic [DATA_W-1:0]    rx_q;
  logic [1:0]           st_code, ta_code;
  logic                 is_rd;

  always_comb begin
    is_rd   = op[1];
    st_code = c45 ? 2'b00 : 2'b01;
    ta_code = 2'b10;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      bcnt_q  <= '0;
      run_q   <= 1'b0;
      tail_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      kind_q  <= KIND_WRITE;
      rx_q    <= '0;
      o_q     <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        frame_q <= {{PRE_LEN{1'b1}}, st_code, op, phy, regad, ta_code, wdata};
        bcnt_q  <= '0;
        run_q   <= 1'b1;
        tail_q  <= 1'b0;
        rd_q    <= is_rd;
        if (is_rd)                    kind_q <= KIND_READ;
        else if (c45 && op == 2'b00)  kind_q <= KIND_ADDR;
        else                          kind_q <= KIND_WRITE;
      end else if (run_q) begin
        if (drive_stb && !tail_q) begin
          if (rd_q && bcnt_q >= CNT_W'(TA_POS)) begin
            oe_q <= 1'b0;
          end else begin
            oe_q <= 1'b1;
            o_q  <= frame_q[FRAME_LEN-1];
          end
        end
        if (rise_stb && !tail_q) begin
          frame_q <= frame_q << 1;
          if (rd_q && bcnt_q >= CNT_W'(DATA_POS)) begin
            rx_q <= {rx_q[DATA_W-2:0], mdio_i};
          end
          if (bcnt_q == CNT_W'(FRAME_LEN - 1)) tail_q <= 1'b1;
          else                                 bcnt_q <= bcnt_q + 1'b1;
        end
        if (fall_stb && tail_q) begin
          run_q  <= 1'b0;
          tail_q <= 1'b0;
          done_q <= 1'b1;
          oe_q   <= 1'b0;
        end
      end
    end
  end

  assign run     = run_q;
  assign done    = done_q;
  assign kind    = kind_q;
  assign rx_data = rx_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mdio_irq_flags.sv
module mdio_irq_flags #(
  parameter int NUM = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [NUM-1:0] set,
  input  logic         clr_we,
  input  logic [NUM:0] clr_data,
  output logic [NUM-1:0] flags
);
  logic [NUM-1:0] flag_q;

  for (genvar i = 0; i < NUM; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                                     flag_q[i] <= 1'b0;
      else if (set[i])                                flag_q[i] <= 1'b1;
      else if (clr_we && (clr_data[NUM] || clr_data[i])) flag_q[i] <= 1'b0;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/mdio_station_mgr.sv
module mdio_station_mgr
  import mdio_sm_pkg::*;
#(
  parameter int DIV_W   = 7,
  parameter int HOLD_W  = 3,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        irq_clr_we,
  input  logic [3:0]  irq_clr_data,
  output logic [2:0]  irq_flags,
  output logic        busy,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [31:0]          cmd_q, cfg_q;
  logic                 accept, start;
  logic                 eng_run, eng_done;
  frame_kind_e          eng_kind;
  logic [DATA_W-1:0]    eng_rx;
  logic                 drive_stb, rise_stb, fall_stb;
  logic [NUM_FLAGS-1:0] flag_set;

  assign busy      = eng_run | eng_done;
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && cmd_wdata[CMD_EN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cfg_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (accept) begin
        cmd_q <= cmd_wdata;
      end else if (eng_done && eng_kind == KIND_READ) begin
        cmd_q[CMD_DATA_LSB +: DATA_W] <= eng_rx;
      end
    end
  end

  always_comb begin
    flag_set = '0;
    if (eng_done) begin
      case (eng_kind)
        KIND_ADDR:  flag_set[FLAG_ADDR]  = 1'b1;
        KIND_READ:  flag_set[FLAG_READ]  = 1'b1;
        default:    flag_set[FLAG_WRITE] = 1'b1;
      endcase
    end
  end

  mdio_mdc_gen #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (eng_run),
    .div       (cfg_q[CFG_DIV_LSB +: DIV_W]),
    .hold      (cfg_q[CFG_HOLD_LSB +: HOLD_W]),
    .mdc       (mdc),
    .drive_stb (drive_stb),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb)
  );

  mdio_frame_eng #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .c45       (cmd_wdata[CMD_C45_BIT]),
    .op        (cmd_wdata[CMD_OP_LSB +: 2]),
    .phy       (cmd_wdata[CMD_PHY_LSB +: ADDR_W]),
    .regad     (cmd_wdata[CMD_REG_LSB +: ADDR_W]),
    .wdata     (cmd_wdata[CMD_DATA_LSB +: DATA_W]),
    .drive_stb (drive_stb),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mdio_i    (mdio_i),
    .run       (eng_run),
    .done      (eng_done),
    .kind      (eng_kind),
    .rx_data   (eng_rx),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  mdio_irq_flags #(.NUM(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (flag_set),
    .clr_we   (irq_clr_we),
    .clr_data (irq_clr_data),
    .flags    (irq_flags)
  );

  assign cmd_rdata = cmd_q;
  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/mdio_station_mgr_chk.sv
module mdio_station_mgr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [31:0] cmd_rdata,
  input logic [31:0] cfg_rdata,
  input logic        mdc,
  input logic        mdio_oe,
  input logic [2:0]  irq_flags,
  input logic        irq_clr_we,
  input logic [3:0]  irq_clr_data
);
  AST_CMD_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_rdata[15:0])); // R1

  AST_ONE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_flags & ~$past(irq_flags))); // R5

  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_flags & ~$past(irq_flags))) |-> $fell(busy)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_flags) & ~irq_flags &
      ~($past(irq_clr_we) ? ($past(irq_clr_data[3]) ? 3'b111 : $past(irq_clr_data[2:0])) : 3'b000))
     == 3'b000)); // R6

  AST_DIV_ZERO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[22:16] == 7'd0) |=> $stable(mdc)); // R8

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R10

  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R10
endmodule

bind mdio_station_mgr mdio_station_mgr_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .cmd_rdata    (cmd_rdata),
  .cfg_rdata    (cfg_rdata),
  .mdc          (mdc),
  .mdio_oe      (mdio_oe),
  .irq_flags    (irq_flags),
  .irq_clr_we   (irq_clr_we),
  .irq_clr_data (irq_clr_data)
);

// File: tb/mdio_station_mgr_tb.sv
`timescale 1ns/1ps
module mdio_station_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_clr_we = 1'b0;
  logic [3:0]  irq_clr_data = '0;
  logic [2:0]  irq_flags;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad = 0;

  // line model state
  int          idx = 0;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  logic [15:0] reply_cur = '0;
  // edge monitor state
  logic mdc_p = 1'b0, o_p = 1'b1, seen_fall = 1'b0, dly_bad = 1'b0;
  int   len = 0, hi_last = 0, lo_last = 0, since = 0, exp_dly = 0, rises = 0;

  always #2 clk = ~clk;

  mdio_station_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_clr_we(irq_clr_we),
    .irq_clr_data(irq_clr_data), .irq_flags(irq_flags), .busy(busy),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // vectors: {c45, op[1:0], phy[4:0], reg[4:0], data[15:0], reply[15:0]}
  localparam logic [44:0] VEC [6] = '{
    {1'b1, 2'b00, 5'h03, 5'h01, 16'h0002, 16'h0000},
    {1'b1, 2'b01, 5'h03, 5'h01, 16'hA5C3, 16'h0000},
    {1'b1, 2'b11, 5'h03, 5'h01, 16'h0000, 16'hBEEF},
    {1'b0, 2'b01, 5'h1F, 5'h00, 16'h0F0F, 16'h0000},
    {1'b0, 2'b10, 5'h0A, 5'h15, 16'h0000, 16'h8001},
    {1'b1, 2'b11, 5'h11, 5'h1E, 16'h1234, 16'h7E5A}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input logic c45, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d, input logic en);
    return {d, 1'b0, op, rg, phy, c45, 1'b0, en};
  endfunction

  task automatic set_cfg(input int dv, input int hd);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {5'b0, 3'(hd), 1'b0, 7'(dv), 16'h0};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr_flags(input logic [3:0] m);
    @(negedge clk);
    irq_clr_we = 1'b1;
    irq_clr_data = m;
    @(negedge clk);
    irq_clr_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [15:0] rep);
    @(negedge clk);
    idx = 0; cap = '0; oecap = '0; reply_cur = rep;
    seen_fall = 1'b0; dly_bad = 1'b0; rises = 0;
    cmd_valid = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // line model: capture on MDC rise, answer on MDC fall
  initial forever begin
    @(posedge mdc);
    if (idx < 64) begin
      cap[63-idx] = mdio_o;
      oecap[63-idx] = mdio_oe;
    end
    idx++;
  end

  initial forever begin
    @(negedge mdc);
    if (idx >= 48 && idx < 64) mdio_i = reply_cur[63-idx];
    else mdio_i = 1'b1;
  end

  // edge timing monitor
  initial forever begin
    @(negedge clk);
    if (mdc != mdc_p) begin
      if (mdc_p) hi_last = len; else lo_last = len;
      if (mdc) rises++;
      len = 1;
    end else begin
      len++;
    end
    if (mdc_p && !mdc) begin
      since = 0;
      seen_fall = 1'b1;
    end else begin
      since++;
    end
    if (seen_fall && mdio_o != o_p && since != exp_dly) dly_bad = 1'b1;
    mdc_p = mdc;
    o_p = mdio_o;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cmd_rdata == 0 && cfg_rdata == 0 && irq_flags == 0, "R11 regs after reset",
        {cmd_rdata, cfg_rdata[28:0], irq_flags}, 64'h0);
    chk(!busy && cmd_ready && !mdc && !mdio_oe, "R11 pins after reset",
        {busy, cmd_ready, mdc, mdio_oe}, 64'h4);

    set_cfg(4, 1);
    exp_dly = 2;
    chk(cfg_rdata == 32'h0104_0000, "R7 cfg readback", cfg_rdata, 64'h0104_0000);

    for (int v = 0; v < 6; v++) begin
      logic c45; logic [1:0] op; logic [4:0] phy, rg; logic [15:0] d, rep;
      logic [63:0] expf; logic [31:0] w, exp_rd; logic [2:0] exp_fl; bit rd;
      {c45, op, phy, rg, d, rep} = VEC[v];
      rd = op[1];
      w = mk_cmd(c45, op, phy, rg, d, 1'b1);
      expf = {32'hFFFF_FFFF, (c45 ? 2'b00 : 2'b01), op, phy, rg, 2'b10, d};
      exp_rd = rd ? {rep, w[15:0]} : w;
      exp_fl = rd ? 3'b001 : ((c45 && op == 2'b00) ? 3'b100 : 3'b010);
      issue(w, rep);
      chk(busy && !cmd_ready, "R10 busy after accept", {busy, cmd_ready}, 64'h2);
      wait_idle();
      if (rd) begin
        chk(cap[63:18] == expf[63:18], "R3 read frame header", cap[63:18], expf[63:18]);
        chk(oecap[63:18] == '1 && oecap[17:0] == '0, "R4 release on turnaround", oecap, {46'h3FFF_FFFF_FFFF, 18'h0});
      end else begin
        chk(cap == expf, "R3 frame bits", cap, expf);
        chk(oecap == '1, "R3 driven throughout", oecap, 64'hFFFF_FFFF_FFFF_FFFF);
      end
      chk(cmd_rdata == exp_rd, "R4 command readback", cmd_rdata, exp_rd);
      chk(irq_flags == exp_fl, "R5 completion flag", irq_flags, exp_fl);
      chk(hi_last == 4 && lo_last == 4, "R7 mdc phases", {hi_last[31:0], lo_last[31:0]}, {32'd4, 32'd4});
      chk(!dly_bad, "R9 hold delay 2", dly_bad, 0);
      chk(!mdc && !mdio_oe, "R10 idle pins", {mdc, mdio_oe}, 0);
      clr_flags(4'hF);
    end

    // R9 other hold and clamped hold
    set_cfg(6, 3);
    exp_dly = 4;
    issue(mk_cmd(1'b0, 2'b01, 5'h05, 5'h09, 16'h5AA5, 1'b1), 16'h0);
    wait_idle();
    chk(!dly_bad && hi_last == 6, "R9 hold 3 delay 4", {dly_bad, hi_last[7:0]}, 64'd6);
    set_cfg(3, 7);
    exp_dly = 2;
    issue(mk_cmd(1'b0, 2'b01, 5'h15, 5'h0A, 16'hC3C3, 1'b1), 16'h0);
    wait_idle();
    chk(!dly_bad && hi_last == 3, "R9 clamped hold", {dly_bad, hi_last[7:0]}, 64'd3);

    // R6 partial clears: write and read flags set
    issue(mk_cmd(1'b0, 2'b10, 5'h02, 5'h03, 16'h0, 1'b1), 16'h1111);
    wait_idle();
    chk(irq_flags == 3'b011, "R5 flags accumulate", irq_flags, 3'b011);
    clr_flags(4'b0001);
    chk(irq_flags == 3'b010, "R6 clear read only", irq_flags, 3'b010);
    clr_flags(4'b0000);
    chk(irq_flags == 3'b010, "R6 zero mask no effect", irq_flags, 3'b010);
    clr_flags(4'b1000);
    chk(irq_flags == 3'b000, "R6 bit3 clears all", irq_flags, 3'b000);

    // R2 enable bit clear
    issue(mk_cmd(1'b1, 2'b01, 5'h07, 5'h07, 16'hDEAD, 1'b0), 16'h0);
    chk(!busy && cmd_rdata == mk_cmd(1'b1, 2'b01, 5'h07, 5'h07, 16'hDEAD, 1'b0),
        "R2 stored without frame", {busy, cmd_rdata}, {1'b0, mk_cmd(1'b1, 2'b01, 5'h07, 5'h07, 16'hDEAD, 1'b0)});
    repeat (20) @(negedge clk);
    chk(rises == 0 && irq_flags == 0, "R2 no mdc no flag", {rises[7:0], irq_flags}, 0);

    // R1 command while busy ignored
    issue(mk_cmd(1'b0, 2'b01, 5'h01, 5'h02, 16'h0101, 1'b1), 16'h0);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_wdata = mk_cmd(1'b1, 2'b11, 5'h1E, 5'h1D, 16'hFFFF, 1'b1);
    repeat (10) @(negedge clk);
    chk(!cmd_ready, "R1 ready low while busy", cmd_ready, 0);
    cmd_valid = 1'b0;
    wait_idle();
    chk(cmd_rdata == mk_cmd(1'b0, 2'b01, 5'h01, 5'h02, 16'h0101, 1'b1), "R1 busy command ignored",
        cmd_rdata, mk_cmd(1'b0, 2'b01, 5'h01, 5'h02, 16'h0101, 1'b1));
    repeat (20) @(negedge clk);
    chk(!busy && irq_flags == 3'b010, "R1 no second frame", {busy, irq_flags}, 3'b010);
    clr_flags(4'hF);

    // R8 zero divider stalls the frame
    set_cfg(0, 0);
    issue(mk_cmd(1'b1, 2'b00, 5'h04, 5'h01, 16'h0010, 1'b1), 16'h0);
    repeat (40) @(negedge clk);
    chk(busy && rises == 0 && !mdc, "R8 stalled with mdc low", {busy, rises[7:0], mdc}, 64'h200);
    set_cfg(2, 0);
    exp_dly = 1;
    wait_idle();
    chk(irq_flags == 3'b100 && rises == 64, "R8 resumes after divider set", {irq_flags, rises[7:0]}, {3'b100, 8'd64});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule